// File: doc/BRIEF.md
# Embedding Bag Sum-Pooling Engine

This block pools one bag of embedding-table rows into a single vector. A sample arrives as a stream of row indices over a valid/ready handshake, and a marker flags the final index of the bag. For each in-range index the engine issues a read on a synchronous table port. It adds the returned row element by element into a saturating accumulator. When the bag closes, it presents the pooled vector on a valid/ready output. The table holds `ROWS` rows of `DIM` signed fixed-point elements. `DIM` covers both short and long row sizes.

Each row fetched during the forward pass is also copied into an on-chip buffer, together with its index. For the backward pass, the engine accepts one gradient vector for the pooled result. It scales this gradient down by a power of two, which gives both the batch average and the learning rate. It then applies the same step to every row that fed the sum. Each row is rewritten as its buffered value minus the step, using only table writes and no reads. A row that appeared more than once in the bag receives the step once per occurrence, and the writes follow bag order.

Top module: `emb_pool_engine`

## Requirements
- R1: While reset is held low, `out_valid`, `tbl_rd_en`, `tbl_wr_en` and `grad_ready` are 0; after release `idx_ready` is 1.
- R2: In the cycle an in-range index is accepted (`idx_valid` and `idx_ready` high), `tbl_rd_en` is 1 and `tbl_addr` equals the index; the table returns the row on `tbl_rdata` one clock later.
- R3: Element `e` of a row and of `out_data` sits at bits `[16e+15:16e]` as 16-bit two's complement. `out_data` is the element-wise sum of the rows of the bag. `out_valid` is 0 at the first rising edge after the last index is accepted, and becomes 1 at the second rising edge after it.
- R4: The sum restarts at the first index of every bag, so bags sent back to back are pooled independently.
- R5: An index of `ROWS` or more issues no read and adds nothing to the sum. It raises `out_err` with that bag's output and is left out of the update. `out_err` is 0 for a bag with no such index.
- R6: Each element accumulates in 24-bit signed arithmetic with saturation. The element is then clamped to the range -32768..32767 on output.
- R7: Once `out_valid` is 1, it stays 1 with `out_data` unchanged until `out_ready` is seen. `idx_ready` stays 0 meanwhile.
- R8: Bags of any length from 1 to 80 indices are pooled correctly.
- R9: `grad_ready` is 1 only after a bag's output has been taken and before the next bag starts. A gradient request wins over a new index in the same cycle. Accepting a gradient starts one table write per cycle from the next cycle on. The writes cover the buffered in-range rows in bag order and then stop.
- R10: The value written for a row is `clamp(row - k*step)`. Here `row` is the value buffered in the forward pass and `k` counts the occurrences of that index in the bag up to and including this one. A duplicated row therefore gets the step applied again on each later write.
- R11: `tbl_rd_en` stays 0 during every update write.
- R12: The step is the gradient element shifted arithmetically right by `LR_SHIFT + BATCH_SHIFT` (2 by default). This power-of-two scaling models the batch average and the learning rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_valid | input | 1 | Index offered |
| idx_ready | output | 1 | Index accepted this cycle when valid |
| idx_data | input | 7 | Row index (one bit wider than the address so out-of-range values can be sent) |
| idx_last | input | 1 | Marks the final index of a bag |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_addr | output | 6 | Table row address |
| tbl_wdata | output | 64 | Updated row for a write |
| tbl_rdata | input | 64 | Row returned one cycle after a read |
| out_valid | output | 1 | Pooled vector available |
| out_ready | input | 1 | Consumer takes the pooled vector |
| out_data | output | 64 | Pooled vector, clamped to 16 bits per element |
| out_err | output | 1 | Bag contained an out-of-range index |
| grad_valid | input | 1 | Gradient offered |
| grad_ready | output | 1 | Gradient accepted this cycle when valid |
| grad_data | input | 64 | Gradient for the last pooled vector |

## Verification
The assertions assume that the table port returns data exactly one cycle after a read. They also assume that a bag never exceeds 80 indices, and that the bench holds its valid signals and data steady until the matching ready. The bench drives all inputs on falling edges. Its memory model registers the read data on the rising edge and applies writes the same way. Every bag it sends stays within the length limit. Gradients are offered only when the bench expects `grad_ready`. Row contents are set directly in the model before each test, so that the clamp cases are reached on purpose rather than by chance.

// File: rtl/emb_pool_engine.sv
module emb_pool_engine #(
  parameter int ROWS = 64,
  parameter int DIM = 4,
  parameter int EW = 16,
  parameter int AW = 24,
  parameter int MAXBAG = 80,
  parameter int LR_SHIFT = 1,
  parameter int BATCH_SHIFT = 1,
  localparam int TAW = $clog2(ROWS),
  localparam int IW = TAW + 1,
  localparam int VW = DIM * EW,
  localparam int CW = $clog2(MAXBAG + 1),
  localparam int SH = LR_SHIFT + BATCH_SHIFT,
  localparam int WW = ((AW > EW + CW) ? AW : EW + CW) + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           idx_valid,
  output logic           idx_ready,
  input  logic [IW-1:0]  idx_data,
  input  logic           idx_last,
  output logic           tbl_rd_en,
  output logic           tbl_wr_en,
  output logic [TAW-1:0] tbl_addr,
  output logic [VW-1:0]  tbl_wdata,
  input  logic [VW-1:0]  tbl_rdata,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [VW-1:0]  out_data,
  output logic           out_err,
  input  logic           grad_valid,
  output logic           grad_ready,
  input  logic [VW-1:0]  grad_data
);

  function automatic logic signed [AW-1:0] sat_acc(input logic signed [AW:0] v);
    if (v[AW] != v[AW-1])
      return v[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
    return v[AW-1:0];
  endfunction

  function automatic logic signed [EW-1:0] clamp_ew(input logic signed [WW-1:0] v);
    logic signed [WW-1:0] hi, lo;
    hi = WW'(2 ** (EW - 1) - 1);
    lo = ~hi;
    if (v > hi) return hi[EW-1:0];
    if (v < lo) return lo[EW-1:0];
    return v[EW-1:0];
  endfunction

  logic           s1_vld, s1_first, s1_last, s1_oob;
  logic [TAW-1:0] s1_idx;
  logic           in_bag, bag_err, buf_ok, upd;
  logic [CW-1:0]  n_buf, k, nb, cnt;
  logic signed [AW-1:0] acc    [DIM];
  logic signed [AW-1:0] acc_nx [DIM];
  logic signed [EW-1:0] step   [DIM];
  logic [TAW-1:0] idx_buf [MAXBAG];
  logic [VW-1:0]  row_buf [MAXBAG];

  wire idx_oob   = idx_data >= IW'(ROWS);
  assign grad_ready = buf_ok && !upd && !out_valid && !s1_vld && !in_bag;
  wire grad_fire = grad_valid && grad_ready;
  assign idx_ready = !upd && !out_valid && !(s1_vld && s1_last) && !grad_fire;
  wire idx_fire  = idx_valid && idx_ready;

  assign tbl_rd_en = idx_fire && !idx_oob;
  assign tbl_wr_en = upd;
  assign tbl_addr  = upd ? idx_buf[k] : idx_data[TAW-1:0];
  assign out_err   = bag_err;

  assign nb = s1_first ? '0 : n_buf;
  wire store = s1_vld && !s1_oob && (nb < CW'(MAXBAG));

  always_comb begin
    cnt = CW'(1);
    for (int j = 0; j < MAXBAG; j++)
      if (CW'(j) < k && idx_buf[j] == idx_buf[k]) cnt = cnt + CW'(1);
  end

  for (genvar e = 0; e < DIM; e++) begin : g_el
    logic signed [EW-1:0] rd_e, row_e;
    logic signed [AW:0]   sum_e;
    logic signed [WW-1:0] prod_e, diff_e;
    assign rd_e   = tbl_rdata[e*EW +: EW];
    assign sum_e  = (s1_first ? {(AW+1){1'b0}} : (AW+1)'(acc[e])) +
                    (s1_oob   ? {(AW+1){1'b0}} : (AW+1)'(rd_e));
    assign acc_nx[e] = sat_acc(sum_e);
    assign out_data[e*EW +: EW] = clamp_ew(WW'(acc[e]));
    assign row_e  = row_buf[k][e*EW +: EW];
    assign prod_e = $signed(WW'(cnt)) * WW'(step[e]);
    assign diff_e = WW'(row_e) - prod_e;
    assign tbl_wdata[e*EW +: EW] = clamp_ew(diff_e);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s1_first <= 1'b0; s1_last <= 1'b0; s1_oob <= 1'b0;
      s1_idx <= '0; in_bag <= 1'b0; bag_err <= 1'b0; buf_ok <= 1'b0;
      upd <= 1'b0; n_buf <= '0; k <= '0; out_valid <= 1'b0;
      for (int e = 0; e < DIM; e++) begin
        acc[e]  <= '0;
        step[e] <= '0;
      end
    end else begin
      s1_vld <= idx_fire;
      if (idx_fire) begin
        s1_first <= !in_bag;
        s1_last  <= idx_last;
        s1_oob   <= idx_oob;
        s1_idx   <= idx_data[TAW-1:0];
        in_bag   <= !idx_last;
      end
      if (s1_vld) begin
        for (int e = 0; e < DIM; e++) acc[e] <= acc_nx[e];
        bag_err <= (s1_first ? 1'b0 : bag_err) | s1_oob;
        n_buf   <= store ? nb + CW'(1) : nb;
        buf_ok  <= s1_last;
        if (s1_last) out_valid <= 1'b1;
      end
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (grad_fire) begin
        upd    <= (n_buf != '0);
        k      <= '0;
        buf_ok <= 1'b0;
        for (int e = 0; e < DIM; e++)
          step[e] <= $signed(grad_data[e*EW +: EW]) >>> SH;
      end
      if (upd) begin
        k <= k + CW'(1);
        if (k == n_buf - CW'(1)) upd <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) begin
      idx_buf[nb] <= s1_idx;
      row_buf[nb] <= tbl_rdata;
    end
  end

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_intake_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !idx_ready);

  assert_no_read_in_update_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en |-> !tbl_rd_en);

  assert_grad_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grad_ready |-> !out_valid && !tbl_wr_en);

  assert_out_follows_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_vld && s1_last));

  assert_oob_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld && s1_oob |-> $past(!tbl_rd_en));

endmodule

// File: tb/emb_pool_engine_tb.sv
module emb_pool_engine_tb;
  localparam int ROWS = 64, DIM = 4, EW = 16, VW = DIM * EW, TAW = 6, IW = 7;
  localparam int NB = 6;
  localparam int BAGS [NB][3] = '{'{1, 5, 0}, '{4, 10, 3}, '{7, 0, 9},
                                  '{3, 63, -1}, '{12, 20, 2}, '{2, 40, 0}};

  logic clk = 0, rst_n = 0;
  logic idx_valid = 0, idx_last = 0, out_ready = 0, grad_valid = 0;
  logic [IW-1:0] idx_data = '0;
  logic [VW-1:0] grad_data = '0, tbl_rdata = '0;
  logic idx_ready, tbl_rd_en, tbl_wr_en, out_valid, out_err, grad_ready;
  logic [TAW-1:0] tbl_addr;
  logic [VW-1:0] tbl_wdata, out_data;
  logic [VW-1:0] mem [ROWS];
  int bag [128];
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  emb_pool_engine u_dut (
    .clk(clk), .rst_n(rst_n), .idx_valid(idx_valid), .idx_ready(idx_ready),
    .idx_data(idx_data), .idx_last(idx_last), .tbl_rd_en(tbl_rd_en),
    .tbl_wr_en(tbl_wr_en), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .tbl_rdata(tbl_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_err(out_err), .grad_valid(grad_valid),
    .grad_ready(grad_ready), .grad_data(grad_data));

  always @(posedge clk) begin
    if (tbl_rd_en) tbl_rdata <= mem[tbl_addr];
    if (tbl_wr_en) mem[tbl_addr] <= tbl_wdata;
  end

  function automatic int el(input logic [VW-1:0] v, input int e);
    return int'($signed(v[e*EW +: EW]));
  endfunction

  function automatic int clamp(input int v);
    return v > 32767 ? 32767 : (v < -32768 ? -32768 : v);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_row(input int r, input int v);
    for (int e = 0; e < DIM; e++) mem[r][e*EW +: EW] = 16'(v);
  endtask

  task automatic send_bag(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idx_valid = 1; idx_data = IW'(bag[i]); idx_last = (i == n - 1);
      #1;
      while (!idx_ready) begin @(negedge clk); #1; end
      if (bag[i] < ROWS)
        chk(tbl_rd_en && tbl_addr == TAW'(bag[i]), "R2 read issued for index", int'(tbl_addr), bag[i]);
      else
        chk(!tbl_rd_en, "R5 no read for out-of-range index", int'(tbl_rd_en), 0);
      @(posedge clk);
    end
    #1 idx_valid = 0; idx_last = 0;
  endtask

  task automatic get_out(input int n, input int hold, input string tag);
    int ex [DIM];
    bit xerr = 0;
    for (int e = 0; e < DIM; e++) ex[e] = 0;
    for (int i = 0; i < n; i++)
      if (bag[i] < ROWS) for (int e = 0; e < DIM; e++) ex[e] += el(mem[bag[i]], e);
      else xerr = 1;
    @(negedge clk);
    chk(out_valid == 0, "R3 no output one edge after last index", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1, "R3 output two edges after last index", int'(out_valid), 1);
    for (int h = 0; h <= hold; h++) begin
      if (h > 0) begin
        @(negedge clk);
        chk(out_valid && !idx_ready && !grad_ready, "R7 output held, intake stalled", int'(out_valid), 1);
      end
      for (int e = 0; e < DIM; e++)
        chk(el(out_data, e) == clamp(ex[e]), tag, el(out_data, e), clamp(ex[e]));
      chk(out_err == xerr, "R5 error flag with output", int'(out_err), int'(xerr));
    end
    out_ready = 1;
    @(posedge clk);
    #1 out_ready = 0;
  endtask

  task automatic do_grad(input int n, input int g0, input int g1, input int g2, input int g3);
    int gs [DIM];
    int xa [128];
    int xd [128][DIM];
    int nw = 0;
    gs[0] = g0 >>> 2; gs[1] = g1 >>> 2; gs[2] = g2 >>> 2; gs[3] = g3 >>> 2;
    for (int i = 0; i < n; i++) begin
      if (bag[i] < ROWS) begin
        int kk = 1;
        for (int j = 0; j < i; j++) if (bag[j] == bag[i]) kk++;
        xa[nw] = bag[i];
        for (int e = 0; e < DIM; e++) xd[nw][e] = clamp(el(mem[bag[i]], e) - kk * gs[e]);
        nw++;
      end
    end
    @(negedge clk);
    grad_valid = 1;
    grad_data = {16'(g3), 16'(g2), 16'(g1), 16'(g0)};
    #1;
    chk(grad_ready == 1, "R9 gradient accepted after output taken", int'(grad_ready), 1);
    @(posedge clk);
    #1 grad_valid = 0;
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      chk(tbl_wr_en == 1, "R9 write each cycle in bag order", int'(tbl_wr_en), 1);
      chk(tbl_rd_en == 0, "R11 no read during update", int'(tbl_rd_en), 0);
      chk(int'(tbl_addr) == xa[w], "R9 write address order", int'(tbl_addr), xa[w]);
      for (int e = 0; e < DIM; e++)
        chk(el(tbl_wdata, e) == xd[w][e], "R10 R12 updated row value", el(tbl_wdata, e), xd[w][e]);
    end
    @(negedge clk);
    chk(tbl_wr_en == 0, "R9 writes stop after last buffered row", int'(tbl_wr_en), 0);
    chk(grad_ready == 0, "R9 no second gradient for same bag", int'(grad_ready), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int e = 0; e < DIM; e++) mem[r][e*EW +: EW] = 16'(r * 13 - e * 7 - 200);
    repeat (3) @(negedge clk);
    chk(!out_valid && !tbl_rd_en && !tbl_wr_en && !grad_ready, "R1 outputs idle in reset",
        int'(out_valid) + int'(tbl_rd_en) + int'(tbl_wr_en) + int'(grad_ready), 0);
    rst_n = 1;
    @(negedge clk);
    chk(idx_ready == 1, "R1 ready after reset", int'(idx_ready), 1);

    for (int b = 0; b < NB; b++) begin
      for (int j = 0; j < BAGS[b][0]; j++)
        bag[j] = (((BAGS[b][1] + j * BAGS[b][2]) % ROWS) + ROWS) % ROWS;
      send_bag(BAGS[b][0]);
      get_out(BAGS[b][0], 0, "R3 R4 pooled sum from table");
    end

    bag[0] = 33;
    send_bag(1); get_out(1, 0, "R8 bag of one");
    for (int j = 0; j < 80; j++) bag[j] = (j * 5) % ROWS;
    send_bag(80); get_out(80, 0, "R8 bag of eighty");

    bag[0] = 3; bag[1] = 70; bag[2] = 5;
    send_bag(3); get_out(3, 0, "R5 out-of-range index skipped");
    bag[0] = 4; bag[1] = 6;
    send_bag(2); get_out(2, 0, "R5 error clears on next bag");

    set_row(60, 30000); set_row(61, -30000);
    bag[0] = 60; bag[1] = 60; bag[2] = 60;
    send_bag(3); get_out(3, 0, "R6 positive clamp");
    bag[0] = 61; bag[1] = 61;
    send_bag(2); get_out(2, 0, "R6 negative clamp");
    bag[0] = 60; bag[1] = 61; bag[2] = 60;
    send_bag(3); get_out(3, 0, "R6 R4 mixed sum in range");

    bag[0] = 1; bag[1] = 2;
    send_bag(2); get_out(2, 4, "R7 held output value");

    bag[0] = 2; bag[1] = 7; bag[2] = 2; bag[3] = 70; bag[4] = 9;
    send_bag(5); get_out(5, 0, "R5 bag before update");
    do_grad(5, 40, -80, 12, -3);

    set_row(12, 32000);
    bag[0] = 12; bag[1] = 12;
    send_bag(2); get_out(2, 0, "R6 bag before clamped update");
    do_grad(2, -32768, -32768, -32768, -32768);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule